// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous static RAM whose write data trails its address by one clock. Address, chip select, write enable and the per-lane write enables are captured on the rising clock edge. The data for a write is captured one edge later and held in a single pending-write store. That store is committed to the array when the next write's data is captured, so reads and writes can alternate on every cycle with no idle cycle between them. A read whose address matches the pending store returns the array word with the store's enabled lanes merged in.

Two select inputs choose how read data reaches the pins. Registered mode returns data one edge after the address edge. Flow-through mode returns it within the address cycle. Latched mode presents it from the falling edge of the address cycle. Data input and output are separate vectors, and an output-enable vector marks when the block drives the bus. A deselect, a sleep input and an asynchronous output-enable input each float the bus.

The depth is 2**ADDR_W words. The full-size configuration uses ADDR_W = 15, giving 32768 words of 36 bits. The default is a small depth so that the bench can sweep every address.

Top module: `lw_sram`

## Requirements
- R1: Every one of the 2**ADDR_W addresses stores a full LANES*LANE_W-bit word independently. With the defaults this is 64 words of 36 bits, in four 9-bit lanes, lane i being bits [9i+8:9i].
- R2: On a write, only the lanes whose bit in lane_we_n is 0 take new data. The other lanes of that word keep their previous value.
- R3: A write cycle with lane_we_n all ones is aborted and changes no word.
- R4: The data for a write whose address is sampled on edge k is taken from din on edge k+1. The value on din at edge k is ignored.
- R5: A read of the address of a write that is not yet committed returns the new data in the enabled lanes and the older data in the others. This holds for a read sampled on the same edge as that write's data, and for any later read.
- R6: With {sel_latch, sel_reg} = 01 (registered), or 11 (treated the same way), a read sampled on edge k is driven from just after edge k+1 until edge k+2.
- R7: With {sel_latch, sel_reg} = 00 (flow-through), a read sampled on edge k is driven from just after edge k until edge k+1.
- R8: With {sel_latch, sel_reg} = 10 (latched), a read sampled on edge k is driven from the falling edge after edge k until the next falling edge.
- R9: A cycle sampled with cs_n high is ignored. It writes nothing, and in the data slot that belongs to it the bus is not driven.
- R10: oe_n high forces dq_oe to zero at once, with no clock edge needed. dq_oe is always either all ones or all zeros, and dout is zero whenever dq_oe is zero.
- R11: zz_sleep high floats the bus at once, and cycles sampled while it is high are ignored.
- R12: While rst_n is low, and right after it, the bus is not driven.
- R13: Reads and writes may alternate on consecutive cycles with no idle cycle, and every read still returns the latest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| zz_sleep | input | 1 | Sleep: floats the bus and ignores cycles |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| lane_we_n | input | LANES | Active-low write enable per 9-bit lane |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sel_latch | input | 1 | Mode select, high picks latched output |
| sel_reg | input | 1 | Mode select, high picks registered output |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | LANES*LANE_W | Per-bit drive enable for the data bus |

## Verification
On every cycle, the checker confirms that oe_n or sleep leaves the bus undriven and that the drive enable is never split. It also confirms that a read accepted in flow-through or registered mode drives the bus in its slot, and that a deselected cycle drives nothing in flow-through mode. Only the bench scenarios can show that the data is right. Those scenarios cover lane merging, aborted writes, forwarding from the pending store during alternating read and write streams, the one-cycle offset of write data, and the falling-edge timing of latched mode, each compared against an arithmetic model of the memory contents.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      zz_sleep,
  input  logic                      cs_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic                      oe_n,
  input  logic                      sel_latch,
  input  logic                      sel_reg,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic [LANES*LANE_W-1:0]   dq_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic              c_act, c_wr;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_ben;

  logic              s_vld;
  logic [ADDR_W-1:0] s_addr;
  logic [DW-1:0]     s_data;
  logic [LANES-1:0]  s_ben;

  logic [DW-1:0]     rd_word, q_data, l_data, dsel;
  logic              q_drv, l_drv, drv;

  wire take   = !zz_sleep && !cs_n;
  wire c_rd   = c_act && !c_wr;
  wire capt   = c_act && c_wr;
  wire hit    = s_vld && (s_addr == c_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_act  <= 1'b0;
      c_wr   <= 1'b0;
      c_addr <= '0;
      c_ben  <= '0;
      s_vld  <= 1'b0;
      s_addr <= '0;
      s_data <= '0;
      s_ben  <= '0;
    end else begin
      c_act  <= take;
      c_wr   <= !we_n;
      c_addr <= addr;
      c_ben  <= ~lane_we_n;
      if (capt) begin
        s_vld  <= 1'b1;
        s_addr <= c_addr;
        s_data <= din;
        s_ben  <= c_ben;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (capt && s_vld)
      for (int i = 0; i < LANES; i++)
        if (s_ben[i]) mem[s_addr][i*LANE_W +: LANE_W] <= s_data[i*LANE_W +: LANE_W];
  end

  always_comb begin
    rd_word = mem[c_addr];
    for (int i = 0; i < LANES; i++)
      if (hit && s_ben[i]) rd_word[i*LANE_W +: LANE_W] = s_data[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_drv  <= 1'b0;
      q_data <= '0;
    end else begin
      q_drv  <= c_rd;
      q_data <= rd_word;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_drv  <= 1'b0;
      l_data <= '0;
    end else begin
      l_drv  <= c_rd;
      l_data <= rd_word;
    end
  end

  always_comb begin
    unique case ({sel_latch, sel_reg})
      2'b00:   begin drv = c_rd;  dsel = rd_word; end
      2'b10:   begin drv = l_drv; dsel = l_data;  end
      default: begin drv = q_drv; dsel = q_data;  end
    endcase
  end

  assign dq_oe = {DW{drv && !oe_n && !zz_sleep}};
  assign dout  = dsel & dq_oe;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          zz_sleep,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          sel_latch,
  input logic          sel_reg,
  input logic [DW-1:0] dq_oe
);
  wire flow = !sel_latch && !sel_reg;
  wire regm = !sel_latch && sel_reg;
  wire acc_rd = !zz_sleep && !cs_n && we_n;

  p_oe_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dq_oe == '0);

  p_oe_uniform_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (&dq_oe));

  p_sleep_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    zz_sleep |-> dq_oe == '0);

  p_flow_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && $past(rst_n) && $past(acc_rd) && !oe_n && !zz_sleep) |-> &dq_oe);

  p_flow_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && $past(rst_n) && $past(cs_n)) |-> dq_oe == '0);

  p_reg_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (regm && $past(rst_n) && $past(rst_n, 2) && $past(acc_rd, 2) && !oe_n && !zz_sleep)
      |-> &dq_oe);
endmodule

bind lw_sram lw_sram_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .zz_sleep(zz_sleep), .cs_n(cs_n), .we_n(we_n),
  .oe_n(oe_n), .sel_latch(sel_latch), .sel_reg(sel_reg), .dq_oe(dq_oe)
);

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, zz = 0, cs_n = 1, we_n = 1, oe_n = 0;
  logic sel_latch = 0, sel_reg = 1;
  logic [LN-1:0] lwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .zz_sleep(zz), .cs_n(cs_n), .we_n(we_n),
    .lane_we_n(lwe_n), .addr(addr), .din(din), .oe_n(oe_n),
    .sel_latch(sel_latch), .sel_reg(sel_reg), .dout(dout), .dq_oe(dq_oe)
  );

  int n_tests = 0, n_fail = 0, kind = 1, junk = 0;
  bit finished = 0;
  logic [DW-1:0] gold [DEPTH];
  bit pend_w = 0, cur_rd = 0, prev_rd = 0;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_d, cur_exp, prev_exp;
  logic [LN-1:0] pend_en;

  function automatic logic [DW-1:0] wdat(int a, int m);
    return {4'(m + 1), 32'(a) * 32'h9E3779B1 ^ 32'(m * 977)};
  endfunction

  task automatic chk(string tag, bit ed, logic [DW-1:0] exp_d);
    logic [DW-1:0] e_oe, e_d;
    e_oe = ed ? '1 : '0;
    e_d  = ed ? exp_d : '0;
    n_tests++;
    if (dq_oe !== e_oe || dout !== e_d) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%h dout=%h expected dq_oe=%h dout=%h", tag, dq_oe, dout, e_oe, e_d);
    end
  endtask

  task automatic check_now(string tag);
    if (kind == 0) chk(tag, cur_rd && !oe_n && !zz, cur_exp);
    else           chk(tag, prev_rd && !oe_n && !zz, prev_exp);
  endtask

  task automatic step(string tag, bit sel, bit wr, logic [LN-1:0] ben_n, int a,
                      logic [DW-1:0] wd, bit oe_off);
    @(negedge clk);
    #2;
    if (kind == 2) chk({tag, " latched"}, cur_rd && !oe_n && !zz, cur_exp);
    cs_n = !sel; we_n = !wr; lwe_n = ben_n; addr = AW'(a); oe_n = oe_off;
    junk++;
    din = pend_w ? pend_d : {4'h9, 32'(junk) * 32'h2545F491};
    @(posedge clk);
    if (pend_w)
      for (int i = 0; i < LN; i++)
        if (pend_en[i]) gold[pend_a][i*LW +: LW] = pend_d[i*LW +: LW];
    prev_rd = cur_rd; prev_exp = cur_exp;
    cur_rd  = sel && !wr && !zz;
    cur_exp = gold[AW'(a)];
    pend_w  = sel && wr && !zz;
    pend_a  = AW'(a); pend_d = wd; pend_en = ~ben_n;
    #2 check_now(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    string mt;
    repeat (3) @(posedge clk);
    #2 chk("R12", 0, '0);
    @(negedge clk) rst_n = 1;
    step("R12", 0, 0, '1, 0, '0, 0);

    for (int m = 0; m < 4; m++) begin
      step("R9", 0, 0, '1, 0, '0, 0);
      step("R9", 0, 0, '1, 0, '0, 0);
      sel_latch = (m >= 2);
      sel_reg   = (m != 1 && m != 2);
      kind      = (m == 1) ? 0 : (m == 2) ? 2 : 1;
      mt        = (kind == 0) ? "R7" : (kind == 1) ? "R6" : "R8";

      for (int a = 0; a < DEPTH; a++) step("R4", 1, 1, '0, a, wdat(a, m), 0);
      for (int a = 0; a < DEPTH; a++) step({"R1/", mt}, 1, 0, '1, a, '0, 0);

      for (int a = 0; a < 16; a++) begin
        step("R2", 1, 1, 4'(a), a, wdat(a, m + 8), 0);
        step("R5", 1, 0, '1, a, '0, 0);
        step("R13", 1, 0, '1, a ^ 1, '0, 0);
        step("R13", 1, 1, 4'(~a), a + 32, wdat(a, m + 16), 0);
        step("R13", 1, 0, '1, a + 32, '0, 0);
      end
      for (int a = 0; a < 16; a++) step("R2", 1, 0, '1, a, '0, 0);

      step("R3", 1, 1, '1, 20, '1, 0);
      step("R3", 1, 0, '1, 20, '0, 0);
      step("R3", 1, 0, '1, 20, '0, 0);

      step("R9", 0, 1, '0, 21, '0, 0);
      step("R9", 0, 0, '1, 21, '0, 0);
      step("R9", 1, 0, '1, 21, '0, 0);
      step("R9", 1, 0, '1, 21, '0, 0);

      zz = 1;
      step("R11", 1, 1, '0, 22, '0, 0);
      step("R11", 1, 0, '1, 22, '0, 0);
      zz = 0;
      step("R11", 1, 0, '1, 22, '0, 0);
      step("R11", 1, 0, '1, 22, '0, 0);
      step("R11", 0, 0, '1, 0, '0, 0);

      step("R10", 1, 0, '1, 23, '0, 1);
      step("R10", 1, 0, '1, 24, '0, 0);
      #1 oe_n = 1;
      #1 check_now("R10");
      oe_n = 0;
      #1 check_now("R10");
      step("R10", 1, 0, '1, 25, '0, 0);
      step("R10", 0, 0, '1, 0, '0, 0);
    end

    step("R12", 1, 0, '1, 3, '0, 0);
    rst_n = 0;
    #1 chk("R12", 0, '0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule